// File: doc/BRIEF.md
# Write-Through Set-Associative Byte Cache

This block is a set-associative cache controller with a byte-wide request port for reads and writes. It has a byte-wide port to a slower next-level memory. Each request address is split into a tag, a set index and a byte offset. The tag is compared against every way of the indexed set at once.

On a hit, the access uses the matching way and needs no next-level reads. On a miss, of either a read or a write, the controller picks a victim way. An invalid way is taken first; when the set is full, the least-recently-used way is taken. The controller then refills the whole line with single-byte reads from next-level memory and completes the access. A write also merges its byte into the line.

Every write, hit or miss, is sent through to next-level memory as one byte at its original address. Because of this, the lower level always holds the current value of every cached byte. Only one request is handled at a time. Four counters report hits, misses, completed reads and completed writes.

Top module: `wt_cache_ctrl`

## Requirements
- R1: With the default parameters, address bits [2:0] are the byte offset, bits [6:3] are the set index and bits [31:7] are the tag. Two addresses that differ only in bits [2:0] fall in the same line.
- R2: An access whose tag matches a valid way of the indexed set is a hit. It responds with `rsp_hit`=1 and issues no next-level read. At most one way of a set ever matches.
- R3: On a miss, the victim is the lowest-numbered invalid way of the set, if one exists. An existing valid line is then not disturbed.
- R4: A miss issues exactly LINE_BYTES next-level reads (`nxt_write`=0). They go to the line start address built from the request's tag and index with offset zero, and then to each following byte in ascending order.
- R5: A write miss allocates the line. After the fill, the written byte is merged into the line, so a later read of that address hits and returns the written byte.
- R6: Every write sends exactly one next-level write (`nxt_write`=1) carrying the request's own address and data. A read sends no next-level write.
- R7: When every way of the set is valid, a miss evicts the way whose most recent completed access is the oldest. Each completed access makes its way the most recently used.
- R8: `hit_count`, `miss_count`, `read_count` and `write_count` each add one for every completed access of their kind.
- R9: Each accepted request produces exactly one `rsp_valid` pulse of one cycle. For a read, `rsp_rdata` holds the byte currently stored at the request address.
- R10: `req_ready` is low from acceptance until the response cycle has ended. A next-level request that is not yet accepted keeps `nxt_valid`, `nxt_write` and `nxt_addr` stable.
- R11: After reset, `req_ready`=1, all counters are zero, no output strobe is high, and every way is invalid, so the first access to any set misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Access hit (1) or missed (0) |
| rsp_rdata | output | 8 | Read byte |
| nxt_valid | output | 1 | Next-level request present |
| nxt_ready | input | 1 | Next level accepts the request |
| nxt_write | output | 1 | 1 = byte write, 0 = byte read |
| nxt_addr | output | ADDR_W | Next-level byte address |
| nxt_wdata | output | 8 | Next-level write byte |
| nxt_rvalid | input | 1 | Read byte returned |
| nxt_rdata | input | 8 | Returned read byte |
| hit_count | output | CNT_W | Completed hits |
| miss_count | output | CNT_W | Completed misses |
| read_count | output | CNT_W | Completed reads |
| write_count | output | CNT_W | Completed writes |

## Verification
Some properties are checked on every cycle:
- No set ever has two matching ways.
- Fill reads stay inside the requested line.
- Write-through addresses equal the held request address.
- Pending next-level requests stay stable.
- The controller is quiet while idle.
- The hit and miss counters together rise by one per response.

Victim choice, LRU ordering, the data returned and write-allocate merging show only across sequences of accesses. The bench exposes these with a reference model of the same policy, directed set-filling and eviction runs, and random traffic concentrated on two sets and six tags.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_FREQ,
        ST_FWAIT,
        ST_WTHRU,
        ST_RESP
    } wtc_state_e;

    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_WAYS       = 4;
    localparam int DEF_SETS       = 16;
    localparam int DEF_LINE_BYTES = 8;
    localparam int DEF_CNT_W      = 32;
endpackage

// File: rtl/wtc_lru.sv
module wtc_lru #(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int SW = $clog2(SETS),
    localparam int AW = $clog2(WAYS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] look_set,
    output logic [AW-1:0] oldest_way,
    input  logic          touch_en,
    input  logic [SW-1:0] touch_set,
    input  logic [AW-1:0] touch_way
);
    logic [WAYS-1:0][AW-1:0] age [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < WAYS; w++) age[s][w] <= AW'(w);
            end else if (touch_en && touch_set == SW'(s)) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (AW'(w) == touch_way)
                        age[s][w] <= '0;
                    else if (age[s][w] < age[s][touch_way])
                        age[s][w] <= age[s][w] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        oldest_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (age[look_set][w] == AW'(WAYS - 1)) oldest_way = AW'(w);
    end
endmodule

// File: rtl/wtc_match.sv
module wtc_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 25,
    localparam int AW = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]            set_valid,
    input  logic [TAG_W-1:0]           look_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit,
    output logic [AW-1:0]              hit_way,
    output logic                       free_found,
    output logic [AW-1:0]              free_way
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = set_valid[w] && (set_tags[w] == look_tag);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way    = '0;
        free_found = 1'b0;
        free_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = AW'(w);
            if (!set_valid[w]) begin
                free_found = 1'b1;
                free_way   = AW'(w);
            end
        end
    end
endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int WAYS       = DEF_WAYS,
    parameter int SETS       = DEF_SETS,
    parameter int LINE_BYTES = DEF_LINE_BYTES,
    parameter int CNT_W      = DEF_CNT_W,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int SW    = $clog2(SETS),
    localparam int AW    = $clog2(WAYS),
    localparam int TAG_W = ADDR_W - SW - OFF_W,
    localparam int DEPTH = SETS * WAYS * LINE_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [7:0]        rsp_rdata,
    output logic              nxt_valid,
    input  logic              nxt_ready,
    output logic              nxt_write,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [7:0]        nxt_wdata,
    input  logic              nxt_rvalid,
    input  logic [7:0]        nxt_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count,
    output logic [CNT_W-1:0]  read_count,
    output logic [CNT_W-1:0]  write_count
);
    wtc_state_e state;

    logic              r_write;
    logic [ADDR_W-1:0] r_addr;
    logic [7:0]        r_wdata;
    logic [AW-1:0]     r_way;
    logic              r_hit;
    logic [OFF_W-1:0]  f_off;

    logic [TAG_W-1:0] r_tag;
    logic [SW-1:0]    r_set;
    logic [OFF_W-1:0] r_off;
    assign r_tag = r_addr[ADDR_W-1 -: TAG_W];
    assign r_set = r_addr[OFF_W +: SW];
    assign r_off = r_addr[OFF_W-1:0];

    logic [WAYS-1:0][TAG_W-1:0] tag_mem [SETS];
    logic [WAYS-1:0]            vld_mem [SETS];
    logic [7:0]                 dat_mem [DEPTH];

    logic [WAYS-1:0] hit_vec;
    logic            look_hit;
    logic [AW-1:0]   hit_way;
    logic            free_found;
    logic [AW-1:0]   free_way;
    logic [AW-1:0]   oldest_way;

    wtc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .set_tags   (tag_mem[r_set]),
        .set_valid  (vld_mem[r_set]),
        .look_tag   (r_tag),
        .hit_vec    (hit_vec),
        .hit        (look_hit),
        .hit_way    (hit_way),
        .free_found (free_found),
        .free_way   (free_way)
    );

    wtc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk        (clk),
        .rst        (rst),
        .look_set   (r_set),
        .oldest_way (oldest_way),
        .touch_en   (state == ST_RESP),
        .touch_set  (r_set),
        .touch_way  (r_way)
    );

    logic last_byte;
    assign last_byte = (f_off == OFF_W'(LINE_BYTES - 1));

    // control and request hold
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            r_write <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
            r_way   <= '0;
            r_hit   <= 1'b0;
            f_off   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    r_write <= req_write;
                    r_addr  <= req_addr;
                    r_wdata <= req_wdata;
                    state   <= ST_LOOK;
                end
                ST_LOOK: begin
                    r_hit <= look_hit;
                    f_off <= '0;
                    if (look_hit) begin
                        r_way <= hit_way;
                        state <= r_write ? ST_WTHRU : ST_RESP;
                    end else begin
                        r_way <= free_found ? free_way : oldest_way;
                        state <= ST_FREQ;
                    end
                end
                ST_FREQ: if (nxt_ready) state <= ST_FWAIT;
                ST_FWAIT: if (nxt_rvalid) begin
                    if (last_byte) state <= r_write ? ST_WTHRU : ST_RESP;
                    else begin
                        f_off <= f_off + 1'b1;
                        state <= ST_FREQ;
                    end
                end
                ST_WTHRU: if (nxt_ready) state <= ST_RESP;
                ST_RESP:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // line data: fill bytes and merged write bytes
    always_ff @(posedge clk) begin
        if (state == ST_FWAIT && nxt_rvalid)
            dat_mem[{r_set, r_way, f_off}] <= nxt_rdata;
        else if (state == ST_WTHRU)
            dat_mem[{r_set, r_way, r_off}] <= r_wdata;
    end

    // tags, valid bits and counters are committed at completion
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
            hit_count   <= '0;
            miss_count  <= '0;
            read_count  <= '0;
            write_count <= '0;
        end else if (state == ST_RESP) begin
            vld_mem[r_set][r_way] <= 1'b1;
            if (r_hit) hit_count  <= hit_count + 1'b1;
            else       miss_count <= miss_count + 1'b1;
            if (r_write) write_count <= write_count + 1'b1;
            else         read_count  <= read_count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (state == ST_RESP) tag_mem[r_set][r_way] <= r_tag;
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_RESP);
        rsp_hit   = r_hit;
        rsp_rdata = dat_mem[{r_set, r_way, r_off}];
        nxt_valid = (state == ST_FREQ) || (state == ST_WTHRU);
        nxt_write = (state == ST_WTHRU);
        nxt_wdata = r_wdata;
        nxt_addr  = (state == ST_WTHRU) ? r_addr : {r_tag, r_set, f_off};
    end
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 3,
    parameter int WAYS   = 4,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              nxt_valid,
    input logic              nxt_ready,
    input logic              nxt_write,
    input logic [ADDR_W-1:0] nxt_addr,
    input logic [ADDR_W-1:0] held_addr,
    input logic [WAYS-1:0]   way_match,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count
);
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_match)); // R2

    AST_FILL_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        (nxt_valid && !nxt_write) |->
            nxt_addr[ADDR_W-1:OFF_W] == held_addr[ADDR_W-1:OFF_W]); // R4

    AST_WTHRU_ADDR: assert property (@(posedge clk) disable iff (rst)
        (nxt_valid && nxt_write) |-> nxt_addr == held_addr); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (hit_count + miss_count) ==
            ($past(hit_count) + $past(miss_count) + CNT_W'(1))); // R8

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!nxt_valid && !rsp_valid)); // R10

    AST_NXT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (nxt_valid && !nxt_ready) |=>
            (nxt_valid && $stable(nxt_addr) && $stable(nxt_write))); // R10
endmodule

bind wt_cache_ctrl wtc_checker #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WAYS(WAYS), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .nxt_valid  (nxt_valid),
    .nxt_ready  (nxt_ready),
    .nxt_write  (nxt_write),
    .nxt_addr   (nxt_addr),
    .held_addr  (r_addr),
    .way_match  (hit_vec),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/wt_cache_ctrl_test.sv
module wt_cache_ctrl_test;
    localparam int NW = 4, NS = 16, LB = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_hit;
    logic [7:0]  rsp_rdata;
    logic        nxt_valid, nxt_write;
    logic        nxt_ready = 1'b0, nxt_rvalid = 1'b0;
    logic [31:0] nxt_addr;
    logic [7:0]  nxt_wdata, nxt_rdata = '0;
    logic [31:0] hit_count, miss_count, read_count, write_count;

    always #2.5 clk = ~clk;

    wt_cache_ctrl uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .nxt_valid(nxt_valid), .nxt_ready(nxt_ready), .nxt_write(nxt_write),
        .nxt_addr(nxt_addr), .nxt_wdata(nxt_wdata),
        .nxt_rvalid(nxt_rvalid), .nxt_rdata(nxt_rdata),
        .hit_count(hit_count), .miss_count(miss_count),
        .read_count(read_count), .write_count(write_count)
    );

    int checks = 0, errors = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // next-level memory model
    logic [7:0]  mem [logic [31:0]];
    int          rd_n = 0, wr_n = 0;
    logic [31:0] rd_log [LB];
    logic [31:0] wr_addr_last = '0;
    logic [7:0]  wr_data_last = '0;
    logic        rd_pend = 1'b0;
    logic [31:0] rd_addr = '0;

    function automatic logic [7:0] memv(logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            nxt_ready  <= 1'b0;
            nxt_rvalid <= 1'b0;
            rd_pend    <= 1'b0;
        end else begin
            nxt_ready  <= ($urandom % 4) != 0;
            nxt_rvalid <= 1'b0;
            if (rd_pend) begin
                rd_pend    <= 1'b0;
                nxt_rvalid <= 1'b1;
                nxt_rdata  <= memv(rd_addr);
            end
            if (nxt_valid && nxt_ready) begin
                if (nxt_write) begin
                    mem[nxt_addr] = nxt_wdata;
                    wr_addr_last  = nxt_addr;
                    wr_data_last  = nxt_wdata;
                    wr_n++;
                end else begin
                    if (rd_n < LB) rd_log[rd_n] = nxt_addr;
                    rd_n++;
                    rd_pend <= 1'b1;
                    rd_addr <= nxt_addr;
                end
            end
        end
    end

    // reference model of the policy
    logic       ref_vld [NS][NW];
    logic [24:0] ref_tag [NS][NW];
    int         ref_age [NS][NW];
    int         e_hit = 0, e_miss = 0, e_rd = 0, e_wr = 0;

    task automatic ref_reset();
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                ref_vld[s][w] = 1'b0;
                ref_age[s][w] = w;
            end
    endtask

    function automatic logic ref_access(logic [31:0] a);
        int s = int'(a[6:3]);
        int way = -1;
        logic hit = 1'b0;
        for (int w = 0; w < NW; w++)
            if (ref_vld[s][w] && ref_tag[s][w] == a[31:7]) begin
                way = w;
                hit = 1'b1;
            end
        if (!hit) begin
            for (int w = NW - 1; w >= 0; w--) if (!ref_vld[s][w]) way = w;
            if (way < 0)
                for (int w = 0; w < NW; w++) if (ref_age[s][w] == NW - 1) way = w;
        end
        for (int w = 0; w < NW; w++)
            if (w != way && ref_age[s][w] < ref_age[s][way]) ref_age[s][w]++;
        ref_age[s][way] = 0;
        ref_vld[s][way] = 1'b1;
        ref_tag[s][way] = a[31:7];
        return hit;
    endfunction

    task automatic access(logic wr, logic [31:0] a, logic [7:0] d, string req);
        logic       exp_hit;
        logic [7:0] exp_data;
        int         w0, n;
        exp_data = memv(a);
        exp_hit  = ref_access(a);
        if (exp_hit) e_hit++; else e_miss++;
        if (wr) e_wr++; else e_rd++;
        rd_n = 0;
        w0   = wr_n;
        @(negedge clk);
        check("R10", {31'd0, req_ready}, 32'd1, "ready before request");
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10", {31'd0, req_ready}, 32'd0, "ready after accept");
        n = 0;
        while (!rsp_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        check("R9", {31'd0, rsp_valid}, 32'd1, "response seen");
        check(req, {31'd0, rsp_hit}, {31'd0, exp_hit}, "hit flag");
        if (!wr) check("R9", {24'd0, rsp_rdata}, {24'd0, exp_data}, "read byte");
        check("R4", rd_n, exp_hit ? 0 : LB, "fill read count");
        if (!exp_hit) begin
            logic ok = 1'b1;
            for (int i = 0; i < LB; i++)
                if (rd_log[i] !== {a[31:3], 3'd0} + 32'(i)) ok = 1'b0;
            check("R4", {31'd0, ok}, 32'd1, "fill address order");
        end
        check("R6", wr_n - w0, wr ? 1 : 0, "write-through count");
        if (wr) begin
            check("R6", wr_addr_last, a, "write-through addr");
            check("R6", {24'd0, wr_data_last}, {24'd0, d}, "write-through data");
        end
        @(negedge clk);
        check("R9", {31'd0, rsp_valid}, 32'd0, "single pulse");
    endtask

    task automatic check_counts(string req);
        check(req, hit_count, e_hit, "hit_count");
        check(req, miss_count, e_miss, "miss_count");
        check(req, read_count, e_rd, "read_count");
        check(req, write_count, e_wr, "write_count");
    endtask

    function automatic logic [31:0] mk(int tag, int set, int off);
        return {25'(tag), 4'(set), 3'(off)};
    endfunction

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        ref_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11", {31'd0, req_ready}, 32'd1, "ready after reset");
        check("R11", {30'd0, rsp_valid, nxt_valid}, 32'd0, "strobes after reset");
        check_counts("R11");

        // R11 / R2 / R9 first miss, then hit on same line with other offset (R1)
        access(1'b0, mk(5, 3, 2), 8'h00, "R11");
        access(1'b0, mk(5, 3, 6), 8'h00, "R1");
        access(1'b0, mk(5, 4, 6), 8'h00, "R1");
        // R6 write hit, R9 read back
        access(1'b1, mk(5, 3, 6), 8'h3C, "R6");
        access(1'b0, mk(5, 3, 6), 8'h00, "R2");
        // R5 write miss allocates, read hits with new byte
        access(1'b1, mk(9, 7, 1), 8'hC3, "R5");
        access(1'b0, mk(9, 7, 1), 8'h00, "R5");
        // R3 fill set 0 with free ways, earlier lines keep hitting
        for (int t = 0; t < 4; t++) access(1'b0, mk(t + 16, 0, t), 8'h00, "R3");
        access(1'b0, mk(16, 0, 0), 8'h00, "R3");
        // R7 eviction order when full
        access(1'b0, mk(20, 0, 5), 8'h00, "R7");
        access(1'b0, mk(17, 0, 5), 8'h00, "R7");
        access(1'b0, mk(16, 0, 5), 8'h00, "R7");
        access(1'b0, mk(19, 0, 5), 8'h00, "R7");
        access(1'b0, mk(18, 0, 5), 8'h00, "R7");
        check_counts("R8");

        // random traffic over two sets and six tags
        for (int i = 0; i < 600; i++) begin
            logic        wr = ($urandom % 3) == 0;
            logic [31:0] a  = mk(int'($urandom % 6) + 40, int'($urandom % 2) + 8,
                                 int'($urandom % 8));
            access(wr, a, 8'($urandom), "R7");
        end
        check_counts("R8");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule